// File: doc/BRIEF.md
# All-Zeros Loss-of-Signal Detector

This block watches a byte-wide receive stream, taken ahead of any descrambler, and flags a loss-of-signal defect when the line has carried nothing but zero bytes for too long. Every byte marked valid either extends a run of consecutive all-zero bytes or, if any bit is set, ends the run. Once the run length reaches a threshold that software programs, the defect is raised on a dedicated output and in a status register. The defect drops on the first valid byte that carries any set bit.

The threshold is a 16-bit count of bytes, held in two writable byte registers (high and low), so software can match any line rate to a time window. For a standards-compliant window, software would program a value between 0x000F and 0x0288, but the hardware accepts any 16-bit value. The register port is a plain single-cycle write strobe with a combinational read mux. Descrambling, framing, overhead extraction and interrupt merging are handled elsewhere.

Top module: `zlos_detector`

## Requirements
- R1: A byte counts as zero only when all 8 bits of `byte_in` are 0. A valid zero byte adds one to the run count at the clock edge that accepts it.
- R2: Register address 0 holds threshold bits 15:8 and address 1 holds bits 7:0. A write with `reg_wr` high stores `reg_wdata` at the clock edge, and reading either address returns the stored byte.
- R3: `los_defect` is 1 whenever the run count is greater than or equal to the effective threshold. It becomes 1 directly after the edge that accepts the Nth consecutive valid zero byte, where N is the threshold.
- R4: A valid byte with any bit set resets the run count to 0, and `los_defect` reads 0 right after that edge.
- R5: A byte presented with `byte_vld` low neither advances nor resets the run count, whatever its value.
- R6: The run count saturates at 0xFFFF and never wraps, so a zero run longer than 65535 bytes keeps the defect set.
- R7: A programmed threshold of 0x0000 behaves as 0x0001: a single valid zero byte declares the defect, and a run count of 0 never does.
- R8: A threshold write takes effect from the following cycle. Writing a value at or below the current run count declares the defect at once, and writing a value above it withdraws the defect, with the run count unchanged.
- R9: Synchronous reset clears the run count and the defect, and loads the threshold 0x0288 (high byte 0x02, low byte 0x88).
- R10: Address 2 is the status register. Bit 0 equals `los_defect` and bits 7:1 read 0. Address 3 reads 0x00, and reads are combinational from `reg_addr`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| byte_vld | input | 1 | Qualifies `byte_in` for this cycle |
| byte_in | input | 8 | Raw received byte, before descrambling |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register address (0 high threshold, 1 low threshold, 2 status) |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Register read data for `reg_addr` |
| los_defect | output | 1 | Loss-of-signal defect |

## Verification
The assertions assume that `byte_in` is a known value whenever `byte_vld` is high. They also assume that a register write lasts one cycle, so the step-by-one and clear-on-mark properties have a defined data byte to judge. The bench drives every input to a known value from time zero, and it changes inputs only just after a rising edge. It also pulses `reg_wr` for exactly one cycle per write, so the stimulus never leaves these assumptions. Because the run count is internal, the bench observes it only through the defect output and the status bit, by placing threshold crossings at chosen byte counts.

// File: rtl/zlos_pkg.sv
package zlos_pkg;

    // Widths of the datapath and register port
    localparam int unsigned ZL_DATA_W   = 8;
    localparam int unsigned ZL_CNT_W    = 16;
    localparam int unsigned ZL_ADDR_W   = 2;
    localparam int unsigned ZL_THR_BYTES = ZL_CNT_W / ZL_DATA_W;
    localparam int unsigned ZL_STATUS_ADDR = ZL_THR_BYTES;
    localparam logic [ZL_CNT_W-1:0] ZL_DEF_THR = 16'h0288;

    typedef logic [ZL_DATA_W-1:0] zl_byte_t;
    typedef logic [ZL_CNT_W-1:0]  zl_count_t;
    typedef logic [ZL_ADDR_W-1:0] zl_addr_t;

    // One register write request
    typedef struct packed {
        logic     en;
        zl_addr_t addr;
        zl_byte_t data;
    } zl_wr_t;

    // One received byte with its qualifier
    typedef struct packed {
        logic     vld;
        zl_byte_t data;
    } zl_rx_t;

    // Saturating increment of the run count
    function automatic zl_count_t zl_sat_inc(input zl_count_t c);
        return (c == '1) ? c : c + zl_count_t'(1);
    endfunction

    // A zero threshold is treated as one
    function automatic zl_count_t zl_eff_thr(input zl_count_t t);
        return (t == '0) ? zl_count_t'(1) : t;
    endfunction

endpackage

// File: rtl/zlos_regs.sv
module zlos_regs
    import zlos_pkg::*;
#(
    parameter zl_count_t RESET_THR = ZL_DEF_THR
) (
    input  logic      clk,
    input  logic      rst,
    input  zl_wr_t    wr,
    input  zl_addr_t  rd_addr,
    input  logic      defect,
    output zl_count_t thr,
    output zl_byte_t  rdata
);
    // Byte slot 0 is the least significant byte of the threshold
    zl_byte_t thr_b [ZL_THR_BYTES];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < ZL_THR_BYTES; i++)
                thr_b[i] <= RESET_THR[i*ZL_DATA_W +: ZL_DATA_W];
        end else if (wr.en) begin
            for (int k = 0; k < ZL_THR_BYTES; k++)
                if (wr.addr == zl_addr_t'(k))
                    thr_b[ZL_THR_BYTES-1-k] <= wr.data;
        end
    end

    // Pack the byte slots into the threshold word
    for (genvar g = 0; g < ZL_THR_BYTES; g++) begin : g_pack
        assign thr[g*ZL_DATA_W +: ZL_DATA_W] = thr_b[g];
    end

    always_comb begin
        rdata = '0;
        for (int k = 0; k < ZL_THR_BYTES; k++)
            if (rd_addr == zl_addr_t'(k))
                rdata = thr_b[ZL_THR_BYTES-1-k];
        if (rd_addr == zl_addr_t'(ZL_STATUS_ADDR))
            rdata = {{(ZL_DATA_W-1){1'b0}}, defect};
    end

endmodule

// File: rtl/zlos_run_counter.sv
module zlos_run_counter
    import zlos_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  zl_rx_t    rx,
    input  zl_count_t thr,
    output zl_count_t cnt,
    output logic      defect
);
    zl_count_t cnt_q;

    always_ff @(posedge clk) begin
        if (rst)
            cnt_q <= '0;
        else if (rx.vld) begin
            if (rx.data == '0)
                cnt_q <= zl_sat_inc(cnt_q);
            else
                cnt_q <= '0;
        end
    end

    assign cnt    = cnt_q;
    assign defect = (cnt_q >= zl_eff_thr(thr));

endmodule

// File: rtl/zlos_detector.sv
module zlos_detector
    import zlos_pkg::*;
#(
    parameter zl_count_t RESET_THR = ZL_DEF_THR
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 byte_vld,
    input  logic [ZL_DATA_W-1:0] byte_in,
    input  logic                 reg_wr,
    input  logic [ZL_ADDR_W-1:0] reg_addr,
    input  logic [ZL_DATA_W-1:0] reg_wdata,
    output logic [ZL_DATA_W-1:0] reg_rdata,
    output logic                 los_defect
);
    zl_wr_t    wr_req;
    zl_rx_t    rx_byte;
    zl_count_t thr_val;
    zl_count_t run_cnt;
    logic      defect_w;

    assign wr_req  = '{en: reg_wr, addr: reg_addr, data: reg_wdata};
    assign rx_byte = '{vld: byte_vld, data: byte_in};

    zlos_regs #(.RESET_THR(RESET_THR)) u_regs (
        .clk     (clk),
        .rst     (rst),
        .wr      (wr_req),
        .rd_addr (reg_addr),
        .defect  (defect_w),
        .thr     (thr_val),
        .rdata   (reg_rdata)
    );

    zlos_run_counter u_run (
        .clk    (clk),
        .rst    (rst),
        .rx     (rx_byte),
        .thr    (thr_val),
        .cnt    (run_cnt),
        .defect (defect_w)
    );

    assign los_defect = defect_w;

endmodule

// File: rtl/zlos_checker.sv
module zlos_checker
    import zlos_pkg::*;
(
    input logic      clk,
    input logic      rst,
    input logic      byte_vld,
    input zl_byte_t  byte_in,
    input logic      reg_wr,
    input zl_addr_t  reg_addr,
    input zl_byte_t  reg_wdata,
    input zl_byte_t  reg_rdata,
    input logic      los_defect,
    input zl_count_t run_cnt,
    input zl_count_t thr_val
);
    // R9: reset leaves a cleared run and no defect
    p_reset_clear_r9: assert property (@(posedge clk)
        rst |=> (run_cnt == '0) && !los_defect);

    // R9: reset loads the default threshold
    p_reset_thr_r9: assert property (@(posedge clk)
        rst |=> thr_val == ZL_DEF_THR);

    // R1: a valid zero byte below saturation adds one
    p_zero_step_r1: assert property (@(posedge clk) disable iff (rst)
        (byte_vld && byte_in == '0 && run_cnt != '1) |=> run_cnt == $past(run_cnt) + zl_count_t'(1));

    // R4: a valid marked byte clears run and defect
    p_mark_clear_r4: assert property (@(posedge clk) disable iff (rst)
        (byte_vld && byte_in != '0) |=> (run_cnt == '0) && !los_defect);

    // R5: an idle cycle leaves the run untouched
    p_idle_hold_r5: assert property (@(posedge clk) disable iff (rst)
        !byte_vld |=> $stable(run_cnt));

    // R6: a saturated run stays saturated under more zeros
    p_no_wrap_r6: assert property (@(posedge clk) disable iff (rst)
        (byte_vld && byte_in == '0 && run_cnt == '1) |=> run_cnt == '1 && los_defect);

    // R7: no defect without at least one zero byte in the run
    p_defect_needs_run_r7: assert property (@(posedge clk) disable iff (rst)
        los_defect |-> run_cnt != '0);

    // R2: a write to the high threshold byte lands there
    p_thr_hi_write_r2: assert property (@(posedge clk) disable iff (rst)
        (reg_wr && reg_addr == zl_addr_t'(0)) |=> thr_val[15:8] == $past(reg_wdata));

    // R10: the status register mirrors the defect output
    p_status_mirror_r10: assert property (@(posedge clk) disable iff (rst)
        (reg_addr == zl_addr_t'(ZL_STATUS_ADDR)) |-> reg_rdata == {7'b0, los_defect});

endmodule

bind zlos_detector zlos_checker u_chk (
    .clk        (clk),
    .rst        (rst),
    .byte_vld   (byte_vld),
    .byte_in    (byte_in),
    .reg_wr     (reg_wr),
    .reg_addr   (reg_addr),
    .reg_wdata  (reg_wdata),
    .reg_rdata  (reg_rdata),
    .los_defect (los_defect),
    .run_cnt    (run_cnt),
    .thr_val    (thr_val)
);

// File: tb/zlos_detector_test.sv
`timescale 1ns/1ps
module zlos_detector_test;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       byte_vld = 1'b0;
    logic [7:0] byte_in = 8'h00;
    logic       reg_wr = 1'b0;
    logic [1:0] reg_addr = 2'd0;
    logic [7:0] reg_wdata = 8'h00;
    logic [7:0] reg_rdata;
    logic       los_defect;

    int total = 0;
    int bad = 0;
    bit finished = 1'b0;

    always #5 clk = ~clk;

    zlos_detector uut (
        .clk        (clk),
        .rst        (rst),
        .byte_vld   (byte_vld),
        .byte_in    (byte_in),
        .reg_wr     (reg_wr),
        .reg_addr   (reg_addr),
        .reg_wdata  (reg_wdata),
        .reg_rdata  (reg_rdata),
        .los_defect (los_defect)
    );

    task automatic check(input string req, input int act, input int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s: actual=0x%0h expected=0x%0h", req, act, exp);
        end
    endtask

    // One byte cycle; outputs are settled 1 ns after the edge
    task automatic send(input logic v, input logic [7:0] d);
        byte_vld = v;
        byte_in  = d;
        @(posedge clk); #1;
        byte_vld = 1'b0;
        byte_in  = 8'h00;
    endtask

    task automatic zeros(input int n);
        for (int i = 0; i < n; i++) send(1'b1, 8'h00);
    endtask

    task automatic wr_reg(input logic [1:0] a, input logic [7:0] d);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        @(posedge clk); #1;
        reg_wr = 1'b0;
    endtask

    task automatic rd_reg(input logic [1:0] a, output logic [7:0] d);
        reg_addr = a;
        #1;
        d = reg_rdata;
    endtask

    task automatic set_thr(input logic [15:0] t);
        wr_reg(2'd0, t[15:8]);
        wr_reg(2'd1, t[7:0]);
    endtask

    task automatic t_reset();
        logic [7:0] d;
        check("R9 defect after reset", los_defect, 0);
        rd_reg(2'd0, d); check("R9 threshold high byte", d, 8'h02);
        rd_reg(2'd1, d); check("R9 threshold low byte", d, 8'h88);
        rd_reg(2'd2, d); check("R10 status after reset", d, 8'h00);
        rd_reg(2'd3, d); check("R10 unused address", d, 8'h00);
    endtask

    task automatic t_default_thr();
        logic [7:0] d;
        zeros(647);
        check("R3 one short of default threshold", los_defect, 0);
        zeros(1);
        check("R3 default threshold reached", los_defect, 1);
        rd_reg(2'd2, d); check("R10 status shows defect", d, 8'h01);
    endtask

    task automatic t_mark_clear();
        logic [7:0] d;
        send(1'b1, 8'h80);
        check("R4 marked byte clears defect", los_defect, 0);
        rd_reg(2'd2, d); check("R4 status cleared", d, 8'h00);
        set_thr(16'h0003);
        zeros(2);
        send(1'b1, 8'h01);
        zeros(2);
        check("R1 single set bit restarts run", los_defect, 0);
        zeros(1);
        check("R1 three zeros after restart", los_defect, 1);
    endtask

    task automatic t_invalid();
        send(1'b1, 8'h55);
        zeros(2);
        for (int i = 0; i < 5; i++) send(1'b0, 8'h00);
        check("R5 invalid zeros do not advance", los_defect, 0);
        for (int i = 0; i < 3; i++) send(1'b0, 8'h55);
        zeros(1);
        check("R5 invalid marks do not reset", los_defect, 1);
    endtask

    task automatic t_regs();
        logic [7:0] d;
        wr_reg(2'd0, 8'h12);
        wr_reg(2'd1, 8'h34);
        rd_reg(2'd0, d); check("R2 high byte readback", d, 8'h12);
        rd_reg(2'd1, d); check("R2 low byte readback", d, 8'h34);
    endtask

    task automatic t_zero_thr();
        send(1'b1, 8'hFF);
        set_thr(16'h0000);
        check("R7 zero threshold with empty run", los_defect, 0);
        zeros(1);
        check("R7 zero threshold acts as one", los_defect, 1);
    endtask

    task automatic t_live_change();
        send(1'b1, 8'h10);
        set_thr(16'd100);
        zeros(10);
        check("R8 below threshold 100", los_defect, 0);
        wr_reg(2'd1, 8'd10);
        check("R8 lowered threshold declares at once", los_defect, 1);
        wr_reg(2'd1, 8'd11);
        check("R8 raised threshold withdraws defect", los_defect, 0);
        zeros(1);
        check("R8 next zero reaches new threshold", los_defect, 1);
    endtask

    task automatic t_saturate();
        send(1'b1, 8'h02);
        set_thr(16'hFFFF);
        zeros(65534);
        check("R6 one short of 0xFFFF", los_defect, 0);
        zeros(1);
        check("R6 count reaches 0xFFFF", los_defect, 1);
        zeros(20);
        check("R6 saturated run keeps defect", los_defect, 1);
        send(1'b1, 8'h40);
        check("R4 marked byte clears saturated run", los_defect, 0);
    endtask

    initial begin
        repeat (3) @(posedge clk);
        #1 rst = 1'b0;
        t_reset();
        t_default_thr();
        t_mark_clear();
        t_invalid();
        t_regs();
        t_zero_thr();
        t_live_change();
        t_saturate();
        if (!finished) begin
            finished = 1'b1;
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        repeat (190000) @(posedge clk);
        if (!finished) begin
            finished = 1'b1;
            total++;
            bad++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

endmodule